// File: doc/BRIEF.md
# Memory Card Bus Decoder with Byte Steering

This block is a synchronous, sampled model of the host side of a 16-bit memory card. It takes the host's two chip enables, output enable, write enable, attribute select, address bit 0 and upper address bits. From these it produces separate high-byte and low-byte read and write strobes for a common-memory array. It also steers data between the host's two byte lanes and the internal byte lanes. A byte transfer addressed to the odd byte is moved across to the host's low lane, so a host with an 8-bit data path can reach both internal bytes.

A strap input picks one of two roles. In the low role the block buffers data and drives the byte strobes. In the high role it decodes the upper address bits into one-hot internal chip selects. The strap is sampled only while the power-up hold-off runs. For a parameterised number of clock cycles after reset, derived from the clock rate and a hold time of a few milliseconds, the block ignores every host access. No write can reach memory during that time. The block has no wait handshake.

Top module: `card_bus_decoder`

## Requirements
- R1: For the first HOLD_CYC rising clock edges after reset is released (HOLD_CYC = CLK_KHZ*HOLD_US/1000), every strobe and chip select stays high and host_d_oe stays 2'b00. Accesses take effect after the HOLD_CYC-th edge.
- R2: The role is the value of role_strap at the last edge of the hold-off (0 = low/data role, 1 = high/decode role). Later changes of role_strap have no effect. A new reset restarts the hold-off and takes the role again.
- R3: A word access (host_ce_n = 2'b00, bit 0 being the low-lane enable) asserts both the high and low strobe of the active kind and moves all 16 bits unchanged in both directions. host_a0 has no effect.
- R4: A byte access on the low-lane enable only (host_ce_n = 2'b10) moves data on the host low lane. With host_a0 = 0 it uses the internal low lane. With host_a0 = 1 it uses the internal high lane, swapping the byte between lanes.
- R5: An odd-byte-only access (host_ce_n = 2'b01) connects the host high lane straight to the internal high lane and uses only the high strobes.
- R6: While host_reg_n is low (attribute space), no common-memory strobe asserts and the host lanes are not driven.
- R7: host_d_oe[1] (high lane) and host_d_oe[0] (low lane) assert only for a read: host_oe_n low, host_we_n high, host_reg_n high and a chip enable low. Lanes not driven read as zero on host_d_out and int_d_out.
- R8: When host_oe_n and host_we_n are both low, the cycle is a write. No read strobe asserts and the host lanes are not driven.
- R9: In the high role no byte strobe or host drive asserts. int_cs_n has bit k low for k equal to the top SEL_W address bits, but only while a chip enable is low and host_reg_n is high. In the low role int_cs_n stays all ones.
- R10: With both chip enables high, no strobe asserts and nothing is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset; restarts the hold-off |
| role_strap | input | 1 | Role select: 0 low/data role, 1 high/decode role |
| host_ce_n | input | 2 | Chip enables, active low; bit 0 low lane, bit 1 high lane |
| host_oe_n | input | 1 | Host output enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_reg_n | input | 1 | Attribute select, active low |
| host_a0 | input | 1 | Address bit 0, selects the odd byte |
| host_addr | input | ADDR_W | Upper host address bits |
| host_d_in | input | DW | Write data from the host |
| host_d_out | output | DW | Read data toward the host |
| host_d_oe | output | 2 | Per-lane drive enable toward the host {high, low} |
| int_d_in | input | DW | Read data from the internal array |
| int_d_out | output | DW | Write data toward the internal array |
| int_we_hi_n | output | 1 | Internal high-byte write strobe, active low |
| int_we_lo_n | output | 1 | Internal low-byte write strobe, active low |
| int_oe_hi_n | output | 1 | Internal high-byte read strobe, active low |
| int_oe_lo_n | output | 1 | Internal low-byte read strobe, active low |
| int_cs_n | output | 2**SEL_W | One-hot internal chip selects, active low |

## Verification
The steering is tried with every chip-enable pattern: word, low-lane byte with each value of address bit 0, odd-byte-only, and none. Each pattern is run as a read and as a write. Host and internal data carry different bytes in every lane, so a wrong lane, a missing swap or a lane left undriven shows up as a wrong value. Attribute-space cycles and cycles with output enable and write enable both low tell apart strobe gating that is correct from gating that only looks at one enable. The hold-off is probed on the edge before and the edge after its end. The strap is changed after it is latched, and then reset again in the decode role.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_WORD,
    ACC_EVEN,
    ACC_ODD_SWAP,
    ACC_ODD_ONLY
  } acc_kind_e;
endpackage

// File: rtl/cbd_powerup_guard.sv
module cbd_powerup_guard #(
  parameter int unsigned HOLD_CYC = 150000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic role_in,
  output logic ready,
  output logic role_q
);
  localparam int unsigned CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      ready  <= 1'b0;
      role_q <= 1'b0;
    end else if (!ready) begin
      role_q <= role_in;
      if (cnt == CW'(HOLD_CYC - 1)) ready <= 1'b1;
      else                          cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cbd_access_classify.sv
module cbd_access_classify
  import cbd_pkg::*;
(
  input  logic [1:0] ce_n,
  input  logic       a0,
  output acc_kind_e  kind
);
  always_comb begin
    unique case (ce_n)
      2'b00:   kind = ACC_WORD;
      2'b10:   kind = a0 ? ACC_ODD_SWAP : ACC_EVEN;
      2'b01:   kind = ACC_ODD_ONLY;
      default: kind = ACC_NONE;
    endcase
  end
endmodule

// File: rtl/cbd_lane_steer.sv
module cbd_lane_steer
  import cbd_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  acc_kind_e       kind,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [DW-1:0]   host_d_in,
  input  logic [DW-1:0]   int_d_in,
  output logic [DW-1:0]   host_d_out,
  output logic [1:0]      host_d_oe,
  output logic [DW-1:0]   int_d_out,
  output logic            we_hi_n,
  output logic            we_lo_n,
  output logic            oe_hi_n,
  output logic            oe_lo_n
);
  localparam int unsigned LW = DW / 2;

  logic int_hi_used, int_lo_used, host_hi_used, host_lo_used;
  logic [LW-1:0] int_hi_wdata, int_lo_wdata, host_hi_rdata, host_lo_rdata;

  always_comb begin
    int_hi_used   = kind inside {ACC_WORD, ACC_ODD_SWAP, ACC_ODD_ONLY};
    int_lo_used   = kind inside {ACC_WORD, ACC_EVEN};
    host_hi_used  = kind inside {ACC_WORD, ACC_ODD_ONLY};
    host_lo_used  = kind inside {ACC_WORD, ACC_EVEN, ACC_ODD_SWAP};

    int_hi_wdata  = (kind == ACC_ODD_SWAP) ? host_d_in[LW-1:0] : host_d_in[DW-1:LW];
    int_lo_wdata  = host_d_in[LW-1:0];
    host_hi_rdata = int_d_in[DW-1:LW];
    host_lo_rdata = (kind == ACC_ODD_SWAP) ? int_d_in[DW-1:LW] : int_d_in[LW-1:0];

    we_hi_n = !(wr_en && int_hi_used);
    we_lo_n = !(wr_en && int_lo_used);
    oe_hi_n = !(rd_en && int_hi_used);
    oe_lo_n = !(rd_en && int_lo_used);

    host_d_oe  = {rd_en && host_hi_used, rd_en && host_lo_used};
    host_d_out = {host_d_oe[1] ? host_hi_rdata : '0,
                  host_d_oe[0] ? host_lo_rdata : '0};
    int_d_out  = {!we_hi_n ? int_hi_wdata : '0,
                  !we_lo_n ? int_lo_wdata : '0};
  end
endmodule

// File: rtl/cbd_select_decode.sv
module cbd_select_decode #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [(1<<SEL_W)-1:0] cs_n
);
  localparam int unsigned NSEL = 1 << SEL_W;

  for (genvar i = 0; i < NSEL; i++) begin : g_cs
    assign cs_n[i] = !(en && (sel == SEL_W'(i)));
  end
endmodule

// File: rtl/card_bus_decoder.sv
module card_bus_decoder
  import cbd_pkg::*;
#(
  parameter int unsigned CLK_KHZ = 50000,
  parameter int unsigned HOLD_US = 3000,
  parameter int unsigned DW      = 16,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned SEL_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     role_strap,
  input  logic [1:0]               host_ce_n,
  input  logic                     host_oe_n,
  input  logic                     host_we_n,
  input  logic                     host_reg_n,
  input  logic                     host_a0,
  input  logic [ADDR_W-1:0]        host_addr,
  input  logic [DW-1:0]            host_d_in,
  output logic [DW-1:0]            host_d_out,
  output logic [1:0]               host_d_oe,
  input  logic [DW-1:0]            int_d_in,
  output logic [DW-1:0]            int_d_out,
  output logic                     int_we_hi_n,
  output logic                     int_we_lo_n,
  output logic                     int_oe_hi_n,
  output logic                     int_oe_lo_n,
  output logic [(1<<SEL_W)-1:0]    int_cs_n
);
  localparam int unsigned HOLD_RAW = (CLK_KHZ * HOLD_US) / 1000;
  localparam int unsigned HOLD_CYC = (HOLD_RAW > 0) ? HOLD_RAW : 1;
  localparam int unsigned NSEL     = 1 << SEL_W;

  logic      pwr_ready, role_hi;
  logic      data_en, wr_en, rd_en, cs_en;
  acc_kind_e kind;

  cbd_powerup_guard #(.HOLD_CYC(HOLD_CYC)) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .role_in (role_strap),
    .ready   (pwr_ready),
    .role_q  (role_hi)
  );

  cbd_access_classify u_class (
    .ce_n (host_ce_n),
    .a0   (host_a0),
    .kind (kind)
  );

  assign data_en = pwr_ready && !role_hi && host_reg_n;
  assign wr_en   = data_en && !host_we_n;
  assign rd_en   = data_en && host_we_n && !host_oe_n;
  assign cs_en   = pwr_ready && role_hi && host_reg_n && (host_ce_n != 2'b11);

  cbd_lane_steer #(.DW(DW)) u_steer (
    .kind       (kind),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .host_d_in  (host_d_in),
    .int_d_in   (int_d_in),
    .host_d_out (host_d_out),
    .host_d_oe  (host_d_oe),
    .int_d_out  (int_d_out),
    .we_hi_n    (int_we_hi_n),
    .we_lo_n    (int_we_lo_n),
    .oe_hi_n    (int_oe_hi_n),
    .oe_lo_n    (int_oe_lo_n)
  );

  cbd_select_decode #(.SEL_W(SEL_W)) u_sel (
    .en   (cs_en),
    .sel  (host_addr[ADDR_W-1 -: SEL_W]),
    .cs_n (int_cs_n)
  );
endmodule

// File: rtl/cbd_checker.sv
module cbd_checker #(
  parameter int unsigned HOLD_CYC = 150000,
  parameter int unsigned NSEL     = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ready,
  input logic            role_q,
  input logic            host_reg_n,
  input logic            host_we_n,
  input logic            we_hi_n,
  input logic            we_lo_n,
  input logic            oe_hi_n,
  input logic            oe_lo_n,
  input logic [1:0]      host_d_oe,
  input logic [NSEL-1:0] int_cs_n
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] win;
  logic          quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        win <= '0;
    else if (win != CW'(HOLD_CYC))     win <= win + 1'b1;
  end

  assign quiet = we_hi_n && we_lo_n && oe_hi_n && oe_lo_n && (host_d_oe == 2'b00);

  p_holdoff_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (win < CW'(HOLD_CYC)) |-> (quiet && (&int_cs_n)));

  p_role_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready)) |-> $stable(role_q));

  p_attr_no_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !host_reg_n |-> quiet);

  p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !host_we_n |-> (oe_hi_n && oe_lo_n && (host_d_oe == 2'b00)));

  p_cs_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~int_cs_n));

  p_decode_role_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    role_q |-> quiet);

  p_data_role_no_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !role_q |-> (&int_cs_n));
endmodule

bind card_bus_decoder cbd_checker #(.HOLD_CYC(HOLD_CYC), .NSEL(NSEL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ready      (pwr_ready),
  .role_q     (role_hi),
  .host_reg_n (host_reg_n),
  .host_we_n  (host_we_n),
  .we_hi_n    (int_we_hi_n),
  .we_lo_n    (int_we_lo_n),
  .oe_hi_n    (int_oe_hi_n),
  .oe_lo_n    (int_oe_lo_n),
  .host_d_oe  (host_d_oe),
  .int_cs_n   (int_cs_n)
);

// File: tb/card_bus_decoder_bench.sv
module card_bus_decoder_bench;
  localparam int HOLD = 20;
  localparam logic [15:0] HD = 16'hA1B2;
  localparam logic [15:0] ID = 16'hC3D4;
  localparam int NV = 14;

  // {ce_n[1:0], oe_n, we_n, reg_n, a0, we_hi_n, we_lo_n, oe_hi_n, oe_lo_n, d_oe[1:0], host_out, int_out}
  localparam logic [43:0] VEC [NV] = '{
    {2'b00, 4'b1010, 4'b0011, 2'b00, 16'h0000, 16'hA1B2}, // R3 word write
    {2'b00, 4'b0110, 4'b1100, 2'b11, 16'hC3D4, 16'h0000}, // R3 word read
    {2'b00, 4'b0111, 4'b1100, 2'b11, 16'hC3D4, 16'h0000}, // R3 word read, a0 set
    {2'b10, 4'b1010, 4'b1011, 2'b00, 16'h0000, 16'h00B2}, // R4 even write
    {2'b10, 4'b1011, 4'b0111, 2'b00, 16'h0000, 16'hB200}, // R4 odd write swapped
    {2'b10, 4'b0110, 4'b1110, 2'b01, 16'h00D4, 16'h0000}, // R4 even read
    {2'b10, 4'b0111, 4'b1101, 2'b01, 16'h00C3, 16'h0000}, // R4 odd read swapped
    {2'b01, 4'b1011, 4'b0111, 2'b00, 16'h0000, 16'hA100}, // R5 odd-only write
    {2'b01, 4'b0111, 4'b1101, 2'b10, 16'hC300, 16'h0000}, // R5 odd-only read
    {2'b00, 4'b1000, 4'b1111, 2'b00, 16'h0000, 16'h0000}, // R6 attribute write
    {2'b00, 4'b0100, 4'b1111, 2'b00, 16'h0000, 16'h0000}, // R6 attribute read
    {2'b11, 4'b0010, 4'b1111, 2'b00, 16'h0000, 16'h0000}, // R10 no enable
    {2'b00, 4'b0010, 4'b0011, 2'b00, 16'h0000, 16'hA1B2}, // R8 both enables low
    {2'b00, 4'b1110, 4'b1111, 2'b00, 16'h0000, 16'h0000}  // R7 idle
  };
  localparam string VTAG [NV] = '{"R3","R3","R3","R4","R4","R4","R4",
                                  "R5","R5","R6","R6","R10","R8","R7"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        role_strap = 1'b0;
  logic [1:0]  host_ce_n = 2'b11;
  logic        host_oe_n = 1'b1, host_we_n = 1'b1, host_reg_n = 1'b1, host_a0 = 1'b0;
  logic [11:0] host_addr = '0;
  logic [15:0] host_d_in = HD, int_d_in = ID;
  logic [15:0] host_d_out, int_d_out;
  logic [1:0]  host_d_oe;
  logic        we_hi_n, we_lo_n, oe_hi_n, oe_lo_n;
  logic [7:0]  int_cs_n;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  card_bus_decoder #(.CLK_KHZ(1000), .HOLD_US(HOLD)) u_card_bus_decoder (
    .clk(clk), .rst_n(rst_n), .role_strap(role_strap), .host_ce_n(host_ce_n),
    .host_oe_n(host_oe_n), .host_we_n(host_we_n), .host_reg_n(host_reg_n),
    .host_a0(host_a0), .host_addr(host_addr), .host_d_in(host_d_in),
    .host_d_out(host_d_out), .host_d_oe(host_d_oe), .int_d_in(int_d_in),
    .int_d_out(int_d_out), .int_we_hi_n(we_hi_n), .int_we_lo_n(we_lo_n),
    .int_oe_hi_n(oe_hi_n), .int_oe_lo_n(oe_lo_n), .int_cs_n(int_cs_n));

  task automatic chk(input string req, input logic [43:0] act, input logic [43:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [43:0] obs();
    return {8'h00, we_hi_n, we_lo_n, oe_hi_n, oe_lo_n, host_d_oe, host_d_out, int_d_out};
  endfunction

  task automatic drive(input logic [1:0] ce, input logic [3:0] ctl);
    @(negedge clk);
    host_ce_n = ce;
    {host_oe_n, host_we_n, host_reg_n, host_a0} = ctl;
    #1;
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0;
    role_strap = strap;
    host_ce_n = 2'b00; host_we_n = 1'b0; host_oe_n = 1'b1; host_reg_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  localparam logic [43:0] QUIET = {8'h00, 4'b1111, 2'b00, 32'h0};
  localparam logic [43:0] WORD_WR = {8'h00, 4'b0011, 2'b00, 16'h0000, 16'hA1B2};

  initial begin
    do_reset(1'b0);
    #1;
    chk("R1 reset state", {obs()[43:8], int_cs_n}, {QUIET[43:8], 8'hFF});
    repeat (HOLD - 1) @(posedge clk);
    #1;
    chk("R1 last inhibited edge", {obs()[43:8], int_cs_n}, {QUIET[43:8], 8'hFF});
    @(posedge clk); #1;
    chk("R1 released after hold", obs(), WORD_WR);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][43:42], VEC[i][41:38]);
      chk(VTAG[i], obs(), {8'h00, VEC[i][37:0]});
      total++;
      if (int_cs_n !== 8'hFF) begin
        bad++;
        $display("FAIL R9: low role cs actual=%h expected=ff", int_cs_n);
      end
    end

    role_strap = 1'b1;
    repeat (3) @(posedge clk);
    drive(2'b00, 4'b1010);
    chk("R2 strap change ignored", obs(), WORD_WR);

    do_reset(1'b0);
    repeat (HOLD / 2) @(posedge clk);
    #1;
    chk("R1 R2 reset restarts hold", obs(), QUIET);

    do_reset(1'b1);
    host_addr = 12'hA00;
    repeat (HOLD) @(posedge clk);
    drive(2'b00, 4'b1010);
    chk("R9 decode role word write", {obs()[43:8], int_cs_n}, {QUIET[43:8], 8'hDF});
    host_addr = 12'h3FF;
    drive(2'b10, 4'b0110);
    chk("R9 decode role read sel1", {obs()[43:8], int_cs_n}, {QUIET[43:8], 8'hFD});
    drive(2'b00, 4'b0100);
    chk("R9 decode role attribute", {obs()[43:8], int_cs_n}, {QUIET[43:8], 8'hFF});
    drive(2'b11, 4'b0110);
    chk("R10 decode role no enable", {obs()[43:8], int_cs_n}, {QUIET[43:8], 8'hFF});

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule